// File: doc/BRIEF.md
# Pipelined 8-Point Winograd DFT

This block computes a forward 8-point discrete Fourier transform on a stream of complex fixed-point samples. Samples arrive one per clock, each marked by a valid strobe. Every eighth accepted sample closes a frame. The frame then passes through a registered chain of add/subtract stages built on the Winograd small-DFT factorisation.

The eight bins leave the block one per clock in natural order. A flag marks bin 0 of each frame. Frames may follow each other with no idle cycles.

The datapath contains no general multiplier. Multiplying by ±j is a swap of the real and imaginary parts with one negation. The single irrational constant, 1/√2, is the ratio 181/256, formed from five shifted copies of the operand and rounded to nearest. Words widen by three bits at the input and keep that width to the output.

Top module: `wino_dft8`

## Requirements
- R1: Each output bin k of a frame equals X[k] = Σ x[n]·e^(−j2πkn/8), with each component within 3 LSB of the exact value. This holds when every input sample has complex magnitude at most 2^(IN_W−1). Outputs are two's complement, IN_W+3 bits wide, with no scaling.
- R2: The block counts samples with `in_valid` high from reset. Eight such samples, in order n = 0..7, form one frame. Cycles with `in_valid` low have no effect on the frame contents, whatever `in_re`/`in_im` carry.
- R3: The eight bins of a frame leave in order k = 0,1,…,7 on eight consecutive cycles, with `out_valid` high on each of them.
- R4: `out_first` is high on the cycle that carries bin 0 and low on every other cycle.
- R5: Bin 0 appears 7 clock edges after the edge that accepts sample 7 of its frame. For a frame sent on consecutive cycles, every bin k therefore appears exactly 14 cycles after sample k was accepted.
- R6: Frames sent back to back with no idle cycle produce back-to-back output bursts. The bursts have no gap and no lost bin.
- R7: After reset `out_valid`, `out_first`, `out_re` and `out_im` are zero. While `out_valid` is low, `out_re` and `out_im` hold their last value.
- R8: The output width is large enough for a full-scale DC frame. Eight samples of −2^(IN_W−1) give bin 0 = −2^(IN_W+2) exactly, and eight samples of 2^(IN_W−1)−1 give 8·(2^(IN_W−1)−1). All other bins are exactly 0.
- R9: The 1/√2 products are exact roundings of v·181/256, computed as floor((181·v + 128)/256). With a real value a in slot n = 1 and zeros elsewhere, and r = floor((181a+128)/256):
  - bins 1, 3, 5 and 7 are exactly (r,−r), (−r,−r), (−r,r) and (r,r);
  - bins 0, 2, 4 and 6 are exactly (a,0), (0,−a), (−a,0) and (0,a).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe; `in_re`/`in_im` are accepted on this cycle |
| in_re | input | IN_W | Real part of the input sample, signed |
| in_im | input | IN_W | Imaginary part of the input sample, signed |
| out_valid | output | 1 | A result bin is present on `out_re`/`out_im` |
| out_first | output | 1 | The present bin is bin 0 of a frame |
| out_re | output | IN_W+3 | Real part of the result bin, signed |
| out_im | output | IN_W+3 | Imaginary part of the result bin, signed |

## Verification
The bench uses several input patterns, each of which separates a different class of fault:
- A single impulse in slot 0 puts the same value on every bin. It exposes ordering and latency faults without any arithmetic in the way.
- A complex tone on bin 3 and pseudo-random frames exercise every butterfly and sign. A swapped or negated term moves energy into the wrong bin.
- A real value in slot 1 routes the signal only through the 1/√2 path. Its odd bins are compared exactly, so truncation or a wrong shift shows up.
- Full-scale DC frames show whether the grown width wraps.
- Frames with idle gaps that carry garbage data check that unstrobed cycles are ignored and that latency is counted from the last sample.

// File: rtl/wino_dft8.sv
module wino_dft8 #(
  parameter int IN_W = 12,
  localparam int OUT_W = IN_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  output logic                    out_valid,
  output logic                    out_first,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);

  localparam int PW = OUT_W + 9;
  localparam int SH = 8;
  localparam logic signed [PW-1:0] HALF = PW'(1 << (SH - 1));

  typedef logic signed [OUT_W-1:0] word_t;
  typedef logic signed [PW-1:0] wide_t;
  typedef struct packed { word_t re; word_t im; } cpx_t;

  function automatic cpx_t cadd(cpx_t a, cpx_t b);
    cpx_t r;
    r.re = a.re + b.re;
    r.im = a.im + b.im;
    return r;
  endfunction

  function automatic cpx_t csub(cpx_t a, cpx_t b);
    cpx_t r;
    r.re = a.re - b.re;
    r.im = a.im - b.im;
    return r;
  endfunction

  function automatic cpx_t cmj(cpx_t a);
    cpx_t r;
    r.re = a.im;
    r.im = -a.re;
    return r;
  endfunction

  function automatic wide_t x181(word_t v);
    wide_t e;
    e = PW'(v);
    return (e <<< 7) + (e <<< 5) + (e <<< 4) + (e <<< 2) + e;
  endfunction

  function automatic word_t rnd(wide_t p);
    wide_t t;
    t = (p + HALF) >>> SH;
    return word_t'(t);
  endfunction

  logic [2:0] wr_idx;
  logic [6:0] vld;
  logic [2:0] rd_idx;
  cpx_t buf_q [7];
  cpx_t s0 [8];
  cpx_t sa [8];
  cpx_t sb [8];
  cpx_t sc [6];
  wide_t p4r, p4i, p5r, p5i;
  cpx_t sm [8];
  cpx_t sd [8];
  cpx_t se [8];
  cpx_t x_in;
  logic last_in;

  assign x_in.re = word_t'(in_re);
  assign x_in.im = word_t'(in_im);
  assign last_in = in_valid && (wr_idx == 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      vld    <= '0;
    end else begin
      if (in_valid) wr_idx <= wr_idx + 1'b1;
      vld <= {vld[5:0], last_in};
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && !last_in) buf_q[wr_idx] <= x_in;
    if (last_in) begin
      for (int i = 0; i < 7; i++) s0[i] <= buf_q[i];
      s0[7] <= x_in;
    end
  end

  always_ff @(posedge clk) begin
    sa[0] <= cadd(s0[0], s0[4]);
    sa[1] <= csub(s0[0], s0[4]);
    sa[2] <= cadd(s0[2], s0[6]);
    sa[3] <= csub(s0[2], s0[6]);
    sa[4] <= cadd(s0[1], s0[5]);
    sa[5] <= csub(s0[1], s0[5]);
    sa[6] <= cadd(s0[3], s0[7]);
    sa[7] <= csub(s0[3], s0[7]);
  end

  always_ff @(posedge clk) begin
    sb[0] <= cadd(sa[0], sa[2]);
    sb[1] <= csub(sa[0], sa[2]);
    sb[2] <= cadd(sa[4], sa[6]);
    sb[3] <= csub(sa[4], sa[6]);
    sb[4] <= cadd(sa[5], sa[7]);
    sb[5] <= csub(sa[5], sa[7]);
    sb[6] <= sa[1];
    sb[7] <= sa[3];
  end

  always_ff @(posedge clk) begin
    sc[0] <= cadd(sb[0], sb[2]);
    sc[1] <= csub(sb[0], sb[2]);
    sc[2] <= sb[1];
    sc[3] <= cmj(sb[3]);
    sc[4] <= sb[6];
    sc[5] <= cmj(sb[7]);
    p5r   <= x181(sb[5].re);
    p5i   <= x181(sb[5].im);
    p4r   <= x181(sb[4].re);
    p4i   <= x181(sb[4].im);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 6; i++) sm[i] <= sc[i];
    sm[6].re <= rnd(p5r);
    sm[6].im <= rnd(p5i);
    sm[7].re <= rnd(p4i);
    sm[7].im <= -rnd(p4r);
  end

  always_ff @(posedge clk) begin
    sd[0] <= sm[0];
    sd[1] <= sm[1];
    sd[2] <= cadd(sm[2], sm[3]);
    sd[3] <= csub(sm[2], sm[3]);
    sd[4] <= cadd(sm[4], sm[5]);
    sd[5] <= csub(sm[4], sm[5]);
    sd[6] <= cadd(sm[6], sm[7]);
    sd[7] <= csub(sm[6], sm[7]);
  end

  always_ff @(posedge clk) begin
    if (vld[5]) begin
      se[0] <= sd[0];
      se[1] <= cadd(sd[4], sd[6]);
      se[2] <= sd[2];
      se[3] <= csub(sd[5], sd[7]);
      se[4] <= sd[1];
      se[5] <= csub(sd[4], sd[6]);
      se[6] <= sd[3];
      se[7] <= cadd(sd[5], sd[7]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      rd_idx    <= '0;
    end else if (vld[6]) begin
      out_valid <= 1'b1;
      out_first <= 1'b1;
      out_re    <= se[0].re;
      out_im    <= se[0].im;
      rd_idx    <= 3'd1;
    end else if (rd_idx != 3'd0) begin
      out_valid <= 1'b1;
      out_first <= 1'b0;
      out_re    <= se[rd_idx].re;
      out_im    <= se[rd_idx].im;
      rd_idx    <= rd_idx + 1'b1;
    end else begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end
  end

endmodule

// File: rtl/wino_dft8_chk.sv
module wino_dft8_chk #(
  parameter int OUT_W = 15
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic                    out_first,
  input logic signed [OUT_W-1:0] out_re,
  input logic signed [OUT_W-1:0] out_im
);

  logic [2:0] seen;
  logic [6:0] done_sr;
  logic [3:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= '0;
      done_sr <= '0;
      run_len <= '0;
    end else begin
      if (in_valid) seen <= seen + 1'b1;
      done_sr <= {done_sr[5:0], in_valid && (seen == 3'd7)};
      if (out_first) run_len <= 4'd1;
      else if (out_valid) run_len <= run_len + 4'd1;
    end
  end

  // R4
  first_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_sr[6] |=> out_first);

  // R4
  no_spurious_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> $past(done_sr[6]));

  // R3
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (run_len == 4'd8));

  // R3
  burst_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> $past(out_valid));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_re) && $stable(out_im)));

endmodule

bind wino_dft8 wino_dft8_chk #(.OUT_W(OUT_W)) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .in_valid(in_valid),
  .out_valid(out_valid),
  .out_first(out_first),
  .out_re(out_re),
  .out_im(out_im)
);

// File: tb/wino_dft8_tb_top.sv
module wino_dft8_tb_top;
  localparam int IN_W = 12;
  localparam int OUT_W = IN_W + 3;
  localparam int TOL = 3;
  localparam real PI = 3.141592653589793;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_re = '0;
  logic signed [IN_W-1:0] in_im = '0;
  logic out_valid, out_first;
  logic signed [OUT_W-1:0] out_re, out_im;

  wino_dft8 #(.IN_W(IN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_first(out_first), .out_re(out_re), .out_im(out_im)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  int src_re [64];
  int src_im [64];
  int src_cyc [64];
  int n_src = 0;
  int cap_re [64];
  int cap_im [64];
  int cap_cyc [64];
  bit cap_first [64];
  int n_cap = 0;
  bit [31:0] seed = 32'h1234_5678;

  always @(negedge clk) begin
    if (rst_n && out_valid && n_cap < 64) begin
      cap_re[n_cap]    = out_re;
      cap_im[n_cap]    = out_im;
      cap_cyc[n_cap]   = cyc;
      cap_first[n_cap] = out_first;
      n_cap++;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int rnd_i(real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic real ref_c(int base, int k, bit imag);
    real acc = 0.0;
    for (int n = 0; n < 8; n++) begin
      real th = 2.0 * PI * real'(k * n) / 8.0;
      if (imag) acc += real'(src_im[base+n]) * $cos(th) - real'(src_re[base+n]) * $sin(th);
      else      acc += real'(src_re[base+n]) * $cos(th) + real'(src_im[base+n]) * $sin(th);
    end
    return acc;
  endfunction

  function automatic int lfsr_val();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16] % 15'd2801) - 1400;
  endfunction

  task automatic begin_case();
    n_src = 0;
    n_cap = 0;
  endtask

  task automatic put(int re, int im);
    in_valid = 1'b1;
    in_re = re[IN_W-1:0];
    in_im = im[IN_W-1:0];
    src_re[n_src] = re;
    src_im[n_src] = im;
    src_cyc[n_src] = cyc;
    n_src++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp_frames(int nfr, string tag);
    chk(n_cap == nfr * 8, {tag, " R3 result count"}, n_cap, nfr * 8);
    for (int i = 0; i < nfr * 8 && i < n_cap; i++) begin
      int er = rnd_i(ref_c((i / 8) * 8, i % 8, 1'b0));
      int ei = rnd_i(ref_c((i / 8) * 8, i % 8, 1'b1));
      chk(iabs(cap_re[i] - er) <= TOL, $sformatf("%s R1 bin %0d re", tag, i % 8), cap_re[i], er);
      chk(iabs(cap_im[i] - ei) <= TOL, $sformatf("%s R1 bin %0d im", tag, i % 8), cap_im[i], ei);
      chk(cap_first[i] == (i % 8 == 0), $sformatf("%s R4 first flag idx %0d", tag, i),
          int'(cap_first[i]), int'(i % 8 == 0));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
    chk(out_first == 1'b0, "R7 reset out_first", int'(out_first), 0);
    chk(out_re == '0 && out_im == '0, "R7 reset data", int'(out_re), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_impulse();
    begin_case();
    put(500, -300);
    for (int n = 1; n < 8; n++) put(0, 0);
    idle(20);
    cmp_frames(1, "impulse");
    for (int k = 0; k < 8 && k < n_cap; k++)
      chk(cap_cyc[k] - src_cyc[k] == 15, $sformatf("R5 latency bin %0d", k),
          cap_cyc[k] - src_cyc[k], 15);
  endtask

  task automatic t_tone();
    begin_case();
    for (int n = 0; n < 8; n++) begin
      real th = 2.0 * PI * real'(3 * n) / 8.0;
      put(rnd_i(1500.0 * $cos(th)), rnd_i(1500.0 * $sin(th)));
    end
    idle(20);
    cmp_frames(1, "tone bin3");
  endtask

  task automatic t_random_b2b();
    begin_case();
    for (int n = 0; n < 24; n++) begin
      int a = lfsr_val();
      int b = lfsr_val();
      put(a, b);
    end
    idle(20);
    cmp_frames(3, "R6 random back-to-back");
    for (int i = 1; i < 24 && i < n_cap; i++)
      chk(cap_cyc[i] == cap_cyc[i-1] + 1, $sformatf("R6 no gap at idx %0d", i),
          cap_cyc[i] - cap_cyc[i-1], 1);
  endtask

  task automatic t_gaps();
    begin_case();
    for (int n = 0; n < 8; n++) begin
      int a = lfsr_val();
      int b = lfsr_val();
      put(a, b);
      in_re = 12'sd1999;
      in_im = -12'sd1999;
      idle(n % 3);
    end
    idle(20);
    cmp_frames(1, "R2 gapped");
    if (n_cap > 0)
      chk(cap_cyc[0] == src_cyc[7] + 8, "R5 latency after last sample",
          cap_cyc[0] - src_cyc[7], 8);
    for (int i = 1; i < 8 && i < n_cap; i++)
      chk(cap_cyc[i] == cap_cyc[i-1] + 1, "R3 consecutive bins", cap_cyc[i] - cap_cyc[i-1], 1);
  endtask

  task automatic t_scale(int a);
    int r = (a * 181 + 128) >>> 8;
    int exp_re [8];
    int exp_im [8];
    exp_re = '{a, r, 0, -r, -a, -r, 0, r};
    exp_im = '{0, -r, -a, -r, 0, r, a, r};
    begin_case();
    put(0, 0);
    put(a, 0);
    for (int n = 2; n < 8; n++) put(0, 0);
    idle(20);
    chk(n_cap == 8, "R9 result count", n_cap, 8);
    for (int k = 0; k < 8 && k < n_cap; k++) begin
      chk(cap_re[k] == exp_re[k], $sformatf("R9 a=%0d bin %0d re", a, k), cap_re[k], exp_re[k]);
      chk(cap_im[k] == exp_im[k], $sformatf("R9 a=%0d bin %0d im", a, k), cap_im[k], exp_im[k]);
    end
  endtask

  task automatic t_fullscale(int vre, int vim);
    begin_case();
    for (int n = 0; n < 8; n++) put(vre, vim);
    idle(20);
    chk(n_cap == 8, "R8 result count", n_cap, 8);
    if (n_cap == 8) begin
      chk(cap_re[0] == 8 * vre, "R8 bin 0 re", cap_re[0], 8 * vre);
      chk(cap_im[0] == 8 * vim, "R8 bin 0 im", cap_im[0], 8 * vim);
      for (int k = 1; k < 8; k++)
        chk(cap_re[k] == 0 && cap_im[k] == 0, $sformatf("R8 bin %0d zero", k), cap_re[k], 0);
    end
  endtask

  task automatic t_hold();
    begin_case();
    put(77, -33);
    for (int n = 1; n < 8; n++) put(0, 0);
    idle(20);
    for (int i = 0; i < 4; i++) begin
      chk(out_valid == 1'b0, "R7 idle out_valid", int'(out_valid), 0);
      chk(out_re == 77, "R7 hold re", int'(out_re), 77);
      chk(out_im == -33, "R7 hold im", int'(out_im), -33);
      in_re = 12'sd555;
      idle(1);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_impulse();
    t_tone();
    t_random_b2b();
    t_gaps();
    t_scale(5);
    t_scale(-5);
    t_scale(1000);
    t_fullscale(-(1 << (IN_W - 1)), 0);
    t_fullscale((1 << (IN_W - 1)) - 1, 0);
    t_fullscale(0, -(1 << (IN_W - 1)));
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R3: got %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule